// File: doc/BRIEF.md
# Spatial Pattern History Table

This block stores spatial footprints that have already been learned: bit vectors with one bit per cache block of a memory region. It files them by the code that began each footprint, not by the data address. The key is built from the program counter of the access that opened a region generation, plus that access's block offset inside the region. Because no data-address bit enters the key, a footprint learned on one region can predict a region that has never been touched.

The table has two ports. The write port takes finished footprints from the generation tracker and files each one under its key. If a way already holds the same key, that way is overwritten. The read port is probed on every trigger access and answers one cycle later with a hit flag and the stored footprint. Storage is set-associative: the low key bits pick a set and the remaining key bits are kept as the tag. Replacement within a set is least-recently-written.

Top module: `spatial_pattern_table`

## Requirements
- R1: The key is the concatenation {pc[PC_ALIGN +: KEY_PC_BITS], offset}, with the offset in the low bits. PC bits below PC_ALIGN and above PC_ALIGN+KEY_PC_BITS-1 have no effect on which entry a lookup or update reaches.
- R2: The response strobe `rspValid` is high in exactly the cycle after a cycle with `lkValid` high, and low otherwise.
- R3: A lookup whose key is stored returns `rspHit`=1 and the stored footprint. A lookup that misses returns `rspHit`=0 and an all-zero `rspPattern`. When `rspValid` is low, `rspHit` is low and `rspPattern` is zero.
- R4: After reset every entry is invalid, so every lookup misses until an update writes it.
- R5: An update whose key is already stored overwrites that way's footprint and never creates a second copy of the key.
- R6: An update with a new key takes the lowest-numbered invalid way of its set. If the set is full, it replaces the way written least recently.
- R7: An update to a key that is already stored makes that way the most recently written in its set.
- R8: When a lookup and an update arrive in the same cycle, the lookup answers with the contents from before the update. A lookup one cycle later sees the new contents.
- R9: Lookups, hits included, do not change the replacement order.
- R10: Two keys that share the same PC bits but differ in offset are separate entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request (trigger access) |
| lkPc | input | PC_WIDTH | PC of the trigger access |
| lkOffset | input | OFFSET_WIDTH | Block offset of the trigger access within its region |
| upValid | input | 1 | Update request carrying a finished footprint |
| upPc | input | PC_WIDTH | Trigger PC of the finished generation |
| upOffset | input | OFFSET_WIDTH | Trigger offset of the finished generation |
| upPattern | input | 2**OFFSET_WIDTH | Footprint to store |
| rspValid | output | 1 | Lookup response strobe, one cycle after the request |
| rspHit | output | 1 | Key was found |
| rspPattern | output | 2**OFFSET_WIDTH | Stored footprint on a hit, zero otherwise |

## Verification
A corrupted tag or valid bit shows up at the read port on the next lookup of that key, as a wrong hit flag or a wrong footprint one cycle after the probe. Corrupted recency state stays hidden until a full set takes a new key. At that point the wrong key is evicted, and the error appears only on a later lookup of the key that should have survived. The stimulus therefore fills sets, adds another key, and probes every key that could be affected. A bench model with per-way write timestamps supplies the expected value of every response.

// File: rtl/spt_pkg.sv
package spt_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // write tag/pattern/valid of the selected way
    logic ageWr;  // write back recency ages of the update set
    logic lkEn;   // capture a lookup response
  } sptStrobe_t;

endpackage

// File: rtl/spt_keygen.sv
module spt_keygen #(
  parameter int PC_WIDTH     = 32,
  parameter int PC_ALIGN     = 2,
  parameter int KEY_PC_BITS  = 10,
  parameter int OFFSET_WIDTH = 4,
  parameter int SET_BITS     = 3,
  localparam int KEY_W       = KEY_PC_BITS + OFFSET_WIDTH,
  localparam int TAG_W       = KEY_W - SET_BITS
) (
  input  logic [PC_WIDTH-1:0]     pc,
  input  logic [OFFSET_WIDTH-1:0] offset,
  output logic [SET_BITS-1:0]     setIdx,
  output logic [TAG_W-1:0]        tag
);

  logic [KEY_W-1:0] key;

  // offset in the low bits, PC bits above instruction alignment on top
  assign key    = {pc[PC_ALIGN +: KEY_PC_BITS], offset};
  assign setIdx = key[SET_BITS-1:0];
  assign tag    = key[KEY_W-1:SET_BITS];

endmodule

// File: rtl/spt_store.sv
module spt_store
  import spt_pkg::*;
#(
  parameter int SET_BITS = 3,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 11,
  parameter int PAT_W    = 16,
  localparam int SETS    = 1 << SET_BITS,
  localparam int AGE_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sptStrobe_t            strobe,
  input  logic [WAYS-1:0]       wrWayOh,
  input  logic [WAYS*AGE_W-1:0] nextAges,
  input  logic [SET_BITS-1:0]   upSet,
  input  logic [TAG_W-1:0]      upTag,
  input  logic [PAT_W-1:0]      upPattern,
  input  logic [SET_BITS-1:0]   lkSet,
  input  logic [TAG_W-1:0]      lkTag,
  output logic [WAYS-1:0]       upHitOh,
  output logic [WAYS-1:0]       upValidOh,
  output logic [WAYS*AGE_W-1:0] upAges,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic [PAT_W-1:0]      rspPattern
);

  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [PAT_W-1:0] patMem [SETS][WAYS];
  logic             valMem [SETS][WAYS];
  logic [AGE_W-1:0] ageMem [SETS][WAYS];

  logic [WAYS-1:0]  lkHitOh;
  logic [PAT_W-1:0] lkPatSel;

  // per-way compare for both ports
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign upHitOh[w]   = valMem[upSet][w] && (tagMem[upSet][w] == upTag);
    assign upValidOh[w] = valMem[upSet][w];
    assign lkHitOh[w]   = valMem[lkSet][w] && (tagMem[lkSet][w] == lkTag);
    assign upAges[w*AGE_W +: AGE_W] = ageMem[upSet][w];
  end

  always_comb begin
    lkPatSel = '0;
    for (int w = 0; w < WAYS; w++) begin
      lkPatSel = lkPatSel | (patMem[lkSet][w] & {PAT_W{lkHitOh[w]}});
    end
  end

  // valid bits and recency ages, reset to empty with ages = way number
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valMem[s][w] <= 1'b0;
          ageMem[s][w] <= AGE_W'(w);
        end
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (strobe.wrEn && wrWayOh[w]) valMem[upSet][w] <= 1'b1;
        if (strobe.ageWr) ageMem[upSet][w] <= nextAges[w*AGE_W +: AGE_W];
      end
    end
  end

  // tag and pattern storage needs no reset
  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (rstN && strobe.wrEn && wrWayOh[w]) begin
        tagMem[upSet][w] <= upTag;
        patMem[upSet][w] <= upPattern;
      end
    end
  end

  // registered lookup response; reads pre-update contents
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspPattern <= '0;
    end else begin
      rspValid   <= strobe.lkEn;
      rspHit     <= strobe.lkEn && (|lkHitOh);
      rspPattern <= strobe.lkEn ? lkPatSel : '0;
    end
  end

endmodule

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_pkg::*;
#(
  parameter int WAYS   = 4,
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  upValid,
  input  logic                  lkValid,
  input  logic [WAYS-1:0]       upHitOh,
  input  logic [WAYS-1:0]       upValidOh,
  input  logic [WAYS*AGE_W-1:0] upAges,
  output sptStrobe_t            strobe,
  output logic [WAYS-1:0]       wrWayOh,
  output logic [WAYS*AGE_W-1:0] nextAges
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]  victimOh;
  logic [AGE_W-1:0] selAge;
  logic             anyHit;
  logic             foundFree;

  assign anyHit = |upHitOh;

  // victim: lowest invalid way, else the oldest way
  always_comb begin
    victimOh  = '0;
    foundFree = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!foundFree && !upValidOh[w]) begin
        victimOh[w] = 1'b1;
        foundFree   = 1'b1;
      end
    end
    if (!foundFree) begin
      for (int w = 0; w < WAYS; w++) begin
        victimOh[w] = (upAges[w*AGE_W +: AGE_W] == OLDEST);
      end
    end
  end

  assign wrWayOh = anyHit ? upHitOh : victimOh;

  // age of the way being written
  always_comb begin
    selAge = '0;
    for (int w = 0; w < WAYS; w++) begin
      selAge = selAge | (upAges[w*AGE_W +: AGE_W] & {AGE_W{wrWayOh[w]}});
    end
  end

  // the written way becomes youngest; younger ways age by one
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (wrWayOh[w]) begin
        nextAges[w*AGE_W +: AGE_W] = '0;
      end else if (upAges[w*AGE_W +: AGE_W] < selAge) begin
        nextAges[w*AGE_W +: AGE_W] = upAges[w*AGE_W +: AGE_W] + 1'b1;
      end else begin
        nextAges[w*AGE_W +: AGE_W] = upAges[w*AGE_W +: AGE_W];
      end
    end
  end

  always_comb begin
    strobe.wrEn  = upValid;
    strobe.ageWr = upValid;
    strobe.lkEn  = lkValid;
  end

endmodule

// File: rtl/spatial_pattern_table.sv
module spatial_pattern_table
  import spt_pkg::*;
#(
  parameter int PC_WIDTH     = 32,
  parameter int PC_ALIGN     = 2,
  parameter int KEY_PC_BITS  = 10,
  parameter int OFFSET_WIDTH = 4,
  parameter int SET_BITS     = 3,
  parameter int WAYS         = 4,
  localparam int PAT_W       = 1 << OFFSET_WIDTH,
  localparam int KEY_W       = KEY_PC_BITS + OFFSET_WIDTH,
  localparam int TAG_W       = KEY_W - SET_BITS,
  localparam int AGE_W       = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lkValid,
  input  logic [PC_WIDTH-1:0]     lkPc,
  input  logic [OFFSET_WIDTH-1:0] lkOffset,
  input  logic                    upValid,
  input  logic [PC_WIDTH-1:0]     upPc,
  input  logic [OFFSET_WIDTH-1:0] upOffset,
  input  logic [PAT_W-1:0]        upPattern,
  output logic                    rspValid,
  output logic                    rspHit,
  output logic [PAT_W-1:0]        rspPattern
);

  logic [SET_BITS-1:0]   lkSet, upSet;
  logic [TAG_W-1:0]      lkTag, upTag;
  logic [WAYS-1:0]       upHitOh, upValidOh, wrWayOh;
  logic [WAYS*AGE_W-1:0] upAges, nextAges;
  sptStrobe_t            strobe;

  spt_keygen #(
    .PC_WIDTH(PC_WIDTH), .PC_ALIGN(PC_ALIGN), .KEY_PC_BITS(KEY_PC_BITS),
    .OFFSET_WIDTH(OFFSET_WIDTH), .SET_BITS(SET_BITS)
  ) i_lkKey (
    .pc(lkPc), .offset(lkOffset), .setIdx(lkSet), .tag(lkTag)
  );

  spt_keygen #(
    .PC_WIDTH(PC_WIDTH), .PC_ALIGN(PC_ALIGN), .KEY_PC_BITS(KEY_PC_BITS),
    .OFFSET_WIDTH(OFFSET_WIDTH), .SET_BITS(SET_BITS)
  ) i_upKey (
    .pc(upPc), .offset(upOffset), .setIdx(upSet), .tag(upTag)
  );

  spt_ctrl #(.WAYS(WAYS)) i_ctrl (
    .upValid(upValid), .lkValid(lkValid),
    .upHitOh(upHitOh), .upValidOh(upValidOh), .upAges(upAges),
    .strobe(strobe), .wrWayOh(wrWayOh), .nextAges(nextAges)
  );

  spt_store #(
    .SET_BITS(SET_BITS), .WAYS(WAYS), .TAG_W(TAG_W), .PAT_W(PAT_W)
  ) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrWayOh(wrWayOh),
    .nextAges(nextAges), .upSet(upSet), .upTag(upTag), .upPattern(upPattern),
    .lkSet(lkSet), .lkTag(lkTag), .upHitOh(upHitOh), .upValidOh(upValidOh),
    .upAges(upAges), .rspValid(rspValid), .rspHit(rspHit),
    .rspPattern(rspPattern)
  );

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int PC_WIDTH     = 32,
  parameter int OFFSET_WIDTH = 4,
  parameter int WAYS         = 4,
  localparam int PAT_W       = 1 << OFFSET_WIDTH
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    lkValid,
  input logic [PC_WIDTH-1:0]     lkPc,
  input logic [OFFSET_WIDTH-1:0] lkOffset,
  input logic                    upValid,
  input logic [PC_WIDTH-1:0]     upPc,
  input logic [OFFSET_WIDTH-1:0] upOffset,
  input logic [PAT_W-1:0]        upPattern,
  input logic                    rspValid,
  input logic                    rspHit,
  input logic [PAT_W-1:0]        rspPattern,
  input logic [WAYS-1:0]         upHitOh
);

  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);

  p_quiet_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rspHit) |-> (rspPattern == '0));

  p_hit_needs_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rspValid) |-> (!rspHit));

  p_single_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(upHitOh));

  p_write_visible_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(upValid) && lkValid &&
     lkPc == $past(upPc) && lkOffset == $past(upOffset))
    |=> (rspHit && rspPattern == $past(upPattern, 2)));

endmodule

bind spatial_pattern_table spt_checker #(
  .PC_WIDTH(PC_WIDTH), .OFFSET_WIDTH(OFFSET_WIDTH), .WAYS(WAYS)
) i_sptChecker (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc), .lkOffset(lkOffset),
  .upValid(upValid), .upPc(upPc), .upOffset(upOffset), .upPattern(upPattern),
  .rspValid(rspValid), .rspHit(rspHit), .rspPattern(rspPattern),
  .upHitOh(upHitOh)
);

// File: tb/test_spatial_pattern_table.sv
`timescale 1ns/1ps
module test_spatial_pattern_table;

  localparam int PCW = 32;
  localparam int ALN = 2;
  localparam int KPB = 10;
  localparam int OFW = 4;
  localparam int SB  = 3;
  localparam int NW  = 4;
  localparam int PW  = 1 << OFW;
  localparam int NS  = 1 << SB;
  localparam int TW  = KPB + OFW - SB;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           lkValid = 1'b0;
  logic [PCW-1:0] lkPc = '0;
  logic [OFW-1:0] lkOffset = '0;
  logic           upValid = 1'b0;
  logic [PCW-1:0] upPc = '0;
  logic [OFW-1:0] upOffset = '0;
  logic [PW-1:0]  upPattern = '0;
  logic           rspValid, rspHit;
  logic [PW-1:0]  rspPattern;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model state
  bit          mVal [NS][NW];
  bit [TW-1:0] mTag [NS][NW];
  bit [PW-1:0] mPat [NS][NW];
  int          mStamp [NS][NW];
  int          tick = 0;

  always #4 clk = ~clk;

  spatial_pattern_table i_spatial_pattern_table (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc), .lkOffset(lkOffset),
    .upValid(upValid), .upPc(upPc), .upOffset(upOffset), .upPattern(upPattern),
    .rspValid(rspValid), .rspHit(rspHit), .rspPattern(rspPattern)
  );

  // R1: key = {pc[ALN +: KPB], offset}
  function automatic bit [KPB+OFW-1:0] keyOf(bit [PCW-1:0] pc, bit [OFW-1:0] off);
    return {pc[ALN +: KPB], off};
  endfunction

  function automatic int findWay(int s, bit [TW-1:0] t);
    for (int w = 0; w < NW; w++) if (mVal[s][w] && mTag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic modelUpdate(bit [PCW-1:0] pc, bit [OFW-1:0] off, bit [PW-1:0] pat);
    bit [KPB+OFW-1:0] k = keyOf(pc, off);
    int s = int'(k[SB-1:0]);
    bit [TW-1:0] t = k[KPB+OFW-1:SB];
    int w = findWay(s, t);
    if (w < 0) begin
      for (int v = 0; v < NW; v++) if (w < 0 && !mVal[s][v]) w = v;
    end
    if (w < 0) begin
      w = 0;
      for (int v = 1; v < NW; v++) if (mStamp[s][v] < mStamp[s][w]) w = v;
    end
    tick++;
    mVal[s][w] = 1'b1; mTag[s][w] = t; mPat[s][w] = pat; mStamp[s][w] = tick;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check response at the following negedge
  task automatic step(string req, bit lv, bit [PCW-1:0] lpc, bit [OFW-1:0] loff,
                      bit uv, bit [PCW-1:0] upc, bit [OFW-1:0] uoff, bit [PW-1:0] upat);
    bit exHit = 1'b0;
    bit [PW-1:0] exPat = '0;
    lkValid = lv; lkPc = lpc; lkOffset = loff;
    upValid = uv; upPc = upc; upOffset = uoff; upPattern = upat;
    if (lv) begin
      bit [KPB+OFW-1:0] k = keyOf(lpc, loff);
      int w = findWay(int'(k[SB-1:0]), k[KPB+OFW-1:SB]);
      if (w >= 0) begin exHit = 1'b1; exPat = mPat[int'(k[SB-1:0])][w]; end
    end
    if (uv) modelUpdate(upc, uoff, upat);
    @(posedge clk);
    @(negedge clk);
    chk({req, " rspValid"}, 64'(rspValid), 64'(lv));
    chk({req, " rspHit"}, 64'(rspHit), 64'(exHit));
    chk({req, " rspPattern"}, 64'(rspPattern), 64'(exPat));
  endtask

  task automatic look(string req, bit [PCW-1:0] pc, bit [OFW-1:0] off);
    step(req, 1'b1, pc, off, 1'b0, '0, '0, '0);
  endtask

  task automatic put(string req, bit [PCW-1:0] pc, bit [OFW-1:0] off, bit [PW-1:0] pat);
    step(req, 1'b0, '0, '0, 1'b1, pc, off, pat);
  endtask

  // PC whose key bits equal v
  function automatic bit [PCW-1:0] pcOf(int v);
    return PCW'(v) << ALN;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mVal[s][w] = 0; mStamp[s][w] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4: reset state at the ports
    chk("R4 reset rspValid", 64'(rspValid), 64'd0);
    chk("R4 reset rspHit", 64'(rspHit), 64'd0);
    chk("R4 reset rspPattern", 64'(rspPattern), 64'd0);
    for (int i = 0; i < 8; i++) look("R4 empty", pcOf(i * 37), OFW'(i));

    // R2 R3: write then read back; idle cycle gives no response
    put("R3 write", pcOf(100), 4'd2, 16'hA5C3);
    look("R3 hit", pcOf(100), 4'd2);
    step("R2 idle", 1'b0, pcOf(100), 4'd2, 1'b0, '0, '0, '0);

    // R8: same-cycle lookup sees old, next cycle sees new
    step("R8 same cycle", 1'b1, pcOf(100), 4'd2, 1'b1, pcOf(100), 4'd2, 16'h0F0F);
    chk("R8 old pattern", 64'(rspPattern), 64'hA5C3);
    look("R8 next cycle", pcOf(100), 4'd2);
    chk("R8 new pattern", 64'(rspPattern), 64'h0F0F);

    // R1: alignment bits and bits above the key field ignored
    look("R1 low pc bits", pcOf(100) | 32'h3, 4'd2);
    chk("R1 low bits hit", 64'(rspHit), 64'd1);
    look("R1 high pc bits", pcOf(100) | 32'hFFF0_0000, 4'd2);
    chk("R1 high bits hit", 64'(rspHit), 64'd1);
    // R10: offset is part of the key
    look("R10 other offset", pcOf(100), 4'd3);
    chk("R10 miss", 64'(rspHit), 64'd0);

    // R6 R9: fill set 5, probe the first key, add a fifth key
    for (int i = 0; i < NW; i++) put("R6 fill", pcOf(200 + i), 4'd5, PW'(16'h1000 + i));
    for (int i = 0; i < 3; i++) look("R9 probe", pcOf(200), 4'd5);
    put("R6 evict", pcOf(210), 4'd5, 16'h7777);
    look("R9 oldest gone", pcOf(200), 4'd5);
    chk("R9 probed key evicted", 64'(rspHit), 64'd0);
    look("R6 neighbour kept", pcOf(201), 4'd5);
    chk("R6 kept", 64'(rspHit), 64'd1);

    // R5 R7: rewrite a stored key, then evict
    put("R5 rewrite", pcOf(201), 4'd5, 16'hBEEF);
    put("R7 evict", pcOf(211), 4'd5, 16'h2222);
    look("R7 refreshed kept", pcOf(201), 4'd5);
    chk("R7 refreshed pattern", 64'(rspPattern), 64'hBEEF);
    look("R7 stale evicted", pcOf(202), 4'd5);
    chk("R7 stale miss", 64'(rspHit), 64'd0);
    look("R5 others", pcOf(203), 4'd5);
    look("R5 others", pcOf(210), 4'd5);

    // R3 R5 R6 R8: random traffic over a small PC pool
    for (int i = 0; i < 4000; i++) begin
      bit lv = ($urandom % 4) != 0;
      bit uv = ($urandom % 3) == 0;
      step("R3 random", lv, pcOf(int'($urandom % 24) * 5) | PCW'($urandom % 4),
           OFW'($urandom), uv, pcOf(int'($urandom % 24) * 5), OFW'($urandom),
           PW'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule